// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Flag Timing and Rewind

This block buffers data words between two unrelated clock domains. Words enter on the write clock when `we` is high and the buffer has room. They leave in arrival order on the read clock when `re` is high and the buffer holds data. The read data sits in a register that the read clock updates. Status comes out as five active-low flags: empty, full, half-full, almost-empty and almost-full. The almost thresholds are fixed by the parameters `AE_OFF` and `AF_OFF`.

Two behaviours are chosen by input pins, and the block captures those pins only while master reset is high. The first pin selects the timing of the almost flags. In synchronous mode, each almost flag is a register in one clock domain. In asynchronous mode, each almost flag is set by a clock edge in one domain and cleared by a clock edge in the other domain. The second pin selects the timing of the rewind function, which returns the read pointer to the first memory location so that stored data can be read again. Rewind can run with normal latency or with zero latency.

Master reset clears all state, zeroes the read data and captures the mode pins. Partial reset clears only the pointers and flags. It keeps the captured modes and leaves the data register as it is.

Top module: `xclk_fifo`

## Requirements
- R1: While `mrst` is high, the outputs take these values: `empty_n`=0, `full_n`=1, `half_n`=1, `almost_empty_n`=0, `almost_full_n`=1 and `dout`=0. The block also captures `cfg_flag_async` and `cfg_rt_slow` while `mrst` is high.
- R2: Words come out on `dout` in the order they were written. Each word appears at the rising read-clock edge where `re` is high and `empty_n` is high. `empty_n` goes high within a few read clocks after a write.
- R3: A read while `empty_n` is low is ignored. `dout` holds its value and the read pointer does not move.
- R4: `full_n` goes low at the write-clock edge that stores the DEPTH-th word. A write while `full_n` is low stores nothing.
- R5: `half_n` is low exactly when the word count seen in the write domain is greater than DEPTH/2.
- R6: This requirement covers synchronous flag mode (`cfg_flag_async`=0 at master reset).
  - `almost_empty_n` is low when the count is at most AE_OFF, and it changes only on read-clock edges.
  - `almost_full_n` is low when the count is at least DEPTH−AF_OFF, and it changes only on write-clock edges.
- R7: This requirement covers asynchronous flag mode (`cfg_flag_async`=1).
  - `almost_empty_n` goes low at the read-clock edge of the read that brings the count to AE_OFF or below. It goes high at the write-clock edge of the write that lifts the count above AE_OFF.
  - `almost_full_n` goes low at the write-clock edge that brings the count to DEPTH−AF_OFF. It goes high at the read-clock edge that brings the count below that level.
- R8: When `rewind` is high at a rising read-clock edge, the read pointer returns to location 0, and `re` is ignored at that edge. In normal-latency mode (`cfg_rt_slow`=1), `dout` is unchanged at that edge, and the next read returns word 0.
- R9: In zero-latency mode (`cfg_rt_slow`=0), word 0 is loaded onto `dout` at the same edge that samples `rewind`, and the next read returns word 1.
- R10: Partial reset (`prst`) returns both pointers to location 0 and puts every flag in its reset state. It keeps the captured flag-timing and rewind modes and leaves `dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, synchronous, active high; must span edges of both clocks |
| prst | input | 1 | Partial reset, synchronous, active high; must span edges of both clocks |
| cfg_flag_async | input | 1 | Captured during master reset: 1 selects asynchronous almost-flag timing |
| cfg_rt_slow | input | 1 | Captured during master reset: 1 selects normal-latency rewind, 0 selects zero latency |
| we | input | 1 | Write enable (write clock) |
| din | input | DW | Write data |
| re | input | 1 | Read enable (read clock) |
| rewind | input | 1 | Rewind request, sampled on the read clock |
| dout | output | DW | Registered read data |
| empty_n | output | 1 | Low when empty (read domain) |
| full_n | output | 1 | Low when full (write domain) |
| half_n | output | 1 | Low when count > DEPTH/2 (write domain) |
| almost_empty_n | output | 1 | Low when count ≤ AE_OFF |
| almost_full_n | output | 1 | Low when count ≥ DEPTH−AF_OFF |

## Verification
The assertions make three assumptions about the inputs:
- Both resets stay high across at least two edges of each clock.
- `rewind` is raised only while the write pointer has not wrapped since the last reset.
- The two modes are changed only through master reset.

The bench holds each reset for four read clocks, which spans several write clocks. It issues every rewind right after a reset and a fill of fewer than DEPTH words. It lets both domains settle for several read clocks before each flag check that depends on a pointer crossing. The only exceptions are the checks that target the exact edge where a flag must change, or must not change, within one domain.

// File: rtl/xf_pkg.sv
package xf_pkg;
  typedef enum logic {FLAG_SYNC = 1'b0, FLAG_ASYNC = 1'b1} flag_mode_e;
  typedef enum logic {RT_ZERO = 1'b0, RT_NORMAL = 1'b1} rt_mode_e;
endpackage

// File: rtl/xf_ram.sv
module xf_ram #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rsrst,
  input  logic          ren,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (wen) store[waddr] <= wdata;
  end

  // registered read port with a synchronous output reset
  always_ff @(posedge rclk) begin
    if (rsrst)    rdata <= '0;
    else if (ren) rdata <= store[raddr];
  end
endmodule

// File: rtl/xf_sync.sv
module xf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/xf_wr_ctl.sv
module xf_wr_ctl #(
  parameter int AW     = 4,
  parameter int AE_OFF = 3,
  parameter int AF_OFF = 3
) (
  input  logic               clk,
  input  logic               mrst,
  input  logic               prst,
  input  logic               cfg_async_pin,
  input  logic               we,
  input  logic [AW:0]        rgray_s,
  input  logic               ae_tog_r_s,
  input  logic               af_tog_r_s,
  output logic [AW:0]        wbin,
  output logic [AW:0]        wgray,
  output logic               mem_we,
  output logic               full_n,
  output logic               half_n,
  output logic               paf_sync_n,
  output logic               ae_tog,
  output logic               af_tog,
  output xf_pkg::flag_mode_e flag_mode
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] CNT_FULL = PW'(DEPTH);
  localparam logic [PW-1:0] CNT_HALF = PW'(DEPTH / 2);
  localparam logic [PW-1:0] CNT_AF   = PW'(DEPTH - AF_OFF);
  localparam logic [PW-1:0] CNT_AE   = PW'(AE_OFF);

  logic [PW-1:0] rbin_s, wbin_nx, cnt_nx;
  logic          clr;

  // gray to binary for the read pointer seen in this domain
  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign rbin_s[i] = ^rgray_s[PW-1:i];
  end

  assign clr     = mrst | prst;
  assign mem_we  = we & full_n;
  assign wbin_nx = wbin + PW'(mem_we);
  assign cnt_nx  = wbin_nx - rbin_s;

  always_ff @(posedge clk) begin
    if (mrst) flag_mode <= xf_pkg::flag_mode_e'(cfg_async_pin);
    if (clr) begin
      wbin       <= '0;
      wgray      <= '0;
      full_n     <= 1'b1;
      half_n     <= 1'b1;
      paf_sync_n <= 1'b1;
      ae_tog     <= 1'b0;
      af_tog     <= 1'b0;
    end else begin
      wbin       <= wbin_nx;
      wgray      <= wbin_nx ^ (wbin_nx >> 1);
      full_n     <= (cnt_nx != CNT_FULL);
      half_n     <= !(cnt_nx > CNT_HALF);
      paf_sync_n <= !(cnt_nx >= CNT_AF);
      // almost-full is set here: asserted while the two toggles differ
      if (cnt_nx >= CNT_AF && af_tog == af_tog_r_s) af_tog <= ~af_tog;
      // almost-empty is cleared here: asserted while the two toggles match
      if (cnt_nx > CNT_AE && ae_tog == ae_tog_r_s) ae_tog <= ~ae_tog;
    end
  end
endmodule

// File: rtl/xf_rd_ctl.sv
module xf_rd_ctl #(
  parameter int AW     = 4,
  parameter int AE_OFF = 3,
  parameter int AF_OFF = 3
) (
  input  logic               clk,
  input  logic               mrst,
  input  logic               prst,
  input  logic               cfg_async_pin,
  input  logic               cfg_rt_slow_pin,
  input  logic               re,
  input  logic               rewind,
  input  logic [AW:0]        wgray_s,
  input  logic               ae_tog_w_s,
  input  logic               af_tog_w_s,
  output logic [AW:0]        rbin,
  output logic [AW:0]        rgray,
  output logic               mem_re,
  output logic [AW-1:0]      mem_raddr,
  output logic               empty_n,
  output logic               pae_sync_n,
  output logic               ae_tog,
  output logic               af_tog,
  output xf_pkg::flag_mode_e flag_mode,
  output xf_pkg::rt_mode_e   rt_mode
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] CNT_AF = PW'(DEPTH - AF_OFF);
  localparam logic [PW-1:0] CNT_AE = PW'(AE_OFF);

  logic [PW-1:0] wbin_s, rbin_nx, cnt_nx;
  logic          clr, do_read, zl_load;

  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign wbin_s[i] = ^wgray_s[PW-1:i];
  end

  assign clr       = mrst | prst;
  assign do_read   = re & empty_n & ~rewind;
  assign zl_load   = rewind & (rt_mode == xf_pkg::RT_ZERO) & (wbin_s != '0);
  assign mem_re    = do_read | zl_load;
  assign mem_raddr = rewind ? '0 : rbin[AW-1:0];
  assign rbin_nx   = rewind ? PW'(zl_load) : rbin + PW'(do_read);
  assign cnt_nx    = wbin_s - rbin_nx;

  always_ff @(posedge clk) begin
    if (mrst) begin
      flag_mode <= xf_pkg::flag_mode_e'(cfg_async_pin);
      rt_mode   <= xf_pkg::rt_mode_e'(cfg_rt_slow_pin);
    end
    if (clr) begin
      rbin       <= '0;
      rgray      <= '0;
      empty_n    <= 1'b0;
      pae_sync_n <= 1'b0;
      ae_tog     <= 1'b0;
      af_tog     <= 1'b0;
    end else begin
      rbin       <= rbin_nx;
      rgray      <= rbin_nx ^ (rbin_nx >> 1);
      empty_n    <= (cnt_nx != '0);
      pae_sync_n <= !(cnt_nx <= CNT_AE);
      // almost-empty is set here, almost-full is cleared here
      if (cnt_nx <= CNT_AE && ae_tog != ae_tog_w_s) ae_tog <= ~ae_tog;
      if (cnt_nx < CNT_AF && af_tog != af_tog_w_s) af_tog <= ~af_tog;
    end
  end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int DW     = 16,
  parameter int AW     = 4,
  parameter int AE_OFF = 3,
  parameter int AF_OFF = 3
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          cfg_flag_async,
  input  logic          cfg_rt_slow,
  input  logic          we,
  input  logic [DW-1:0] din,
  input  logic          re,
  input  logic          rewind,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n,
  output logic          almost_empty_n,
  output logic          almost_full_n
);
  localparam int PW = AW + 1;
  localparam int XW = PW + 2;

  logic [PW-1:0]      wbin, wgray, rbin, rgray;
  logic [XW-1:0]      to_w, to_w_s, to_r, to_r_s;
  logic               mem_we, mem_re, paf_sync_n, pae_sync_n;
  logic               ae_tog_w, af_tog_w, ae_tog_r, af_tog_r;
  logic [AW-1:0]      mem_raddr;
  logic               clr;
  xf_pkg::flag_mode_e wr_flag_mode, rd_flag_mode;
  xf_pkg::rt_mode_e   rd_rt_mode;

  assign clr  = mrst | prst;
  assign to_w = {rgray, ae_tog_r, af_tog_r};
  assign to_r = {wgray, ae_tog_w, af_tog_w};

  xf_sync #(.W(XW)) u_sync_r2w (.clk(wclk), .rst(clr), .d(to_w), .q(to_w_s));
  xf_sync #(.W(XW)) u_sync_w2r (.clk(rclk), .rst(clr), .d(to_r), .q(to_r_s));

  xf_wr_ctl #(.AW(AW), .AE_OFF(AE_OFF), .AF_OFF(AF_OFF)) u_wr (
    .clk(wclk), .mrst(mrst), .prst(prst), .cfg_async_pin(cfg_flag_async),
    .we(we), .rgray_s(to_w_s[XW-1:2]), .ae_tog_r_s(to_w_s[1]),
    .af_tog_r_s(to_w_s[0]), .wbin(wbin), .wgray(wgray), .mem_we(mem_we),
    .full_n(full_n), .half_n(half_n), .paf_sync_n(paf_sync_n),
    .ae_tog(ae_tog_w), .af_tog(af_tog_w), .flag_mode(wr_flag_mode)
  );

  xf_rd_ctl #(.AW(AW), .AE_OFF(AE_OFF), .AF_OFF(AF_OFF)) u_rd (
    .clk(rclk), .mrst(mrst), .prst(prst), .cfg_async_pin(cfg_flag_async),
    .cfg_rt_slow_pin(cfg_rt_slow), .re(re), .rewind(rewind),
    .wgray_s(to_r_s[XW-1:2]), .ae_tog_w_s(to_r_s[1]), .af_tog_w_s(to_r_s[0]),
    .rbin(rbin), .rgray(rgray), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .empty_n(empty_n), .pae_sync_n(pae_sync_n), .ae_tog(ae_tog_r),
    .af_tog(af_tog_r), .flag_mode(rd_flag_mode), .rt_mode(rd_rt_mode)
  );

  xf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .wen(mem_we), .waddr(wbin[AW-1:0]), .wdata(din),
    .rclk(rclk), .rsrst(mrst), .ren(mem_re), .raddr(mem_raddr), .rdata(dout)
  );

  // asynchronous timing: each flag is the XOR of a register per domain
  assign almost_empty_n = (rd_flag_mode == xf_pkg::FLAG_ASYNC) ?
                          (ae_tog_r ^ ae_tog_w) : pae_sync_n;
  assign almost_full_n  = (wr_flag_mode == xf_pkg::FLAG_ASYNC) ?
                          ~(af_tog_w ^ af_tog_r) : paf_sync_n;
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst,
  input logic          prst,
  input logic          we,
  input logic          re,
  input logic          rewind,
  input logic          full_n,
  input logic          half_n,
  input logic          empty_n,
  input logic [DW-1:0] dout,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic          rt_normal
);
  p_mrst_rd_r1: assert property (@(posedge rclk)
    mrst |=> (dout == '0 && !empty_n));
  p_mrst_wr_r1: assert property (@(posedge wclk)
    mrst |=> (full_n && half_n));
  p_empty_read_hold_r3: assert property (@(posedge rclk) disable iff (mrst || prst)
    (!empty_n && re && !rewind) |=> ($stable(dout) && $stable(rbin)));
  p_no_overflow_r4: assert property (@(posedge wclk) disable iff (mrst || prst)
    (!full_n && we) |=> $stable(wbin));
  p_full_is_half_r5: assert property (@(posedge wclk) disable iff (mrst || prst)
    !full_n |-> !half_n);
  p_rewind_normal_r8: assert property (@(posedge rclk) disable iff (mrst || prst)
    (rewind && rt_normal) |=> (rbin == '0 && $stable(dout)));
  p_rewind_zero_r9: assert property (@(posedge rclk) disable iff (mrst || prst)
    (rewind && !rt_normal) |=> (rbin <= (AW+1)'(1)));
  p_prst_ptr_r10: assert property (@(posedge rclk)
    (prst && !mrst) |=> (rbin == '0 && !empty_n && $stable(dout)));
endmodule

bind xclk_fifo xclk_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .we(we), .re(re),
  .rewind(rewind), .full_n(full_n), .half_n(half_n), .empty_n(empty_n),
  .dout(dout), .wbin(wbin), .rbin(rbin),
  .rt_normal(rd_rt_mode == xf_pkg::RT_NORMAL)
);

// File: tb/xclk_fifo_bench.sv
module xclk_fifo_bench;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0;
  logic mrst = 1'b1, prst = 1'b0, cfg_flag_async = 1'b0, cfg_rt_slow = 1'b1;
  logic we = 1'b0, re = 1'b0, rewind = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic empty_n, full_n, half_n, almost_empty_n, almost_full_n;
  int errors = 0, checks = 0;

  always #4 wclk = ~wclk;
  always #6 rclk = ~rclk;

  xclk_fifo #(.DW(DW), .AW(AW), .AE_OFF(3), .AF_OFF(3)) u_xclk_fifo (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst),
    .cfg_flag_async(cfg_flag_async), .cfg_rt_slow(cfg_rt_slow),
    .we(we), .din(din), .re(re), .rewind(rewind), .dout(dout),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic master_reset(input logic fa, input logic slow);
    @(negedge wclk);
    cfg_flag_async = fa; cfg_rt_slow = slow;
    we = 0; re = 0; rewind = 0; mrst = 1;
    repeat (4) @(negedge rclk);
    mrst = 0;
    repeat (2) @(negedge rclk);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge wclk); we = 1; din = d;
    @(negedge wclk); we = 0;
  endtask

  task automatic rd();
    @(negedge rclk); re = 1;
    @(negedge rclk); re = 0;
  endtask

  task automatic pulse_rewind();
    @(negedge rclk); rewind = 1;
    @(negedge rclk); rewind = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
  endtask

  task automatic t_reset();
    master_reset(1'b0, 1'b1);
    chk("R1 empty_n", 32'(empty_n), 0);
    chk("R1 full_n", 32'(full_n), 1);
    chk("R1 half_n", 32'(half_n), 1);
    chk("R1 almost_empty_n", 32'(almost_empty_n), 0);
    chk("R1 almost_full_n", 32'(almost_full_n), 1);
    chk("R1 dout", 32'(dout), 0);
  endtask

  task automatic t_order_and_empty();
    master_reset(1'b0, 1'b1);
    for (int i = 0; i < 5; i++) wr(16'hA000 + 16'(i));
    settle();
    chk("R2 empty_n after writes", 32'(empty_n), 1);
    for (int i = 0; i < 5; i++) begin
      rd();
      chk("R2 read order", 32'(dout), 32'(16'hA000 + 16'(i)));
    end
    settle();
    chk("R2 empty_n after drain", 32'(empty_n), 0);
    rd();
    chk("R3 dout held on empty read", 32'(dout), 32'h0000A004);
    chk("R3 still empty", 32'(empty_n), 0);
    wr(16'h5A5A); settle(); rd();
    chk("R3 pointer unmoved", 32'(dout), 32'h5A5A);
    master_reset(1'b0, 1'b1);
    chk("R1 dout cleared after data", 32'(dout), 0);
  endtask

  task automatic t_full_half();
    master_reset(1'b0, 1'b1);
    for (int i = 0; i < DEPTH; i++) begin
      wr(16'(i * 3 + 1));
      if (i == DEPTH / 2 - 1) chk("R5 half_n at DEPTH/2", 32'(half_n), 1);
      if (i == DEPTH / 2)     chk("R5 half_n above DEPTH/2", 32'(half_n), 0);
    end
    chk("R4 full_n at DEPTH", 32'(full_n), 0);
    wr(16'hDEAD);
    chk("R4 full_n after extra write", 32'(full_n), 0);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      rd();
      chk("R4 data after full", 32'(dout), 32'(i * 3 + 1));
    end
    settle();
    chk("R4 extra write dropped", 32'(empty_n), 0);
    chk("R5 half_n after drain", 32'(half_n), 1);
  endtask

  task automatic t_sync_flags();
    master_reset(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) wr(16'(i));
    settle();
    chk("R6 almost_empty_n at 3", 32'(almost_empty_n), 0);
    wr(16'h3);
    chk("R6 almost_empty_n not moved by write clock", 32'(almost_empty_n), 0);
    settle();
    chk("R6 almost_empty_n at 4", 32'(almost_empty_n), 1);
    for (int i = 4; i < 12; i++) wr(16'(i));
    settle();
    chk("R6 almost_full_n at 12", 32'(almost_full_n), 1);
    wr(16'hC);
    chk("R6 almost_full_n at 13", 32'(almost_full_n), 0);
    rd();
    chk("R6 almost_full_n not moved by read clock", 32'(almost_full_n), 0);
    settle();
    chk("R6 almost_full_n at 12 after read", 32'(almost_full_n), 1);
  endtask

  task automatic t_async_flags();
    master_reset(1'b1, 1'b1);
    for (int i = 0; i < 3; i++) wr(16'(i));
    settle();
    chk("R7 almost_empty_n at 3", 32'(almost_empty_n), 0);
    wr(16'h3);
    chk("R7 almost_empty_n cleared by write edge", 32'(almost_empty_n), 1);
    settle();
    rd();
    chk("R7 almost_empty_n set by read edge", 32'(almost_empty_n), 0);
    for (int i = 0; i < 9; i++) wr(16'(i + 4));
    settle();
    chk("R7 almost_full_n at 12", 32'(almost_full_n), 1);
    wr(16'hD);
    chk("R7 almost_full_n set by write edge", 32'(almost_full_n), 0);
    settle();
    rd();
    chk("R7 almost_full_n cleared by read edge", 32'(almost_full_n), 1);
  endtask

  task automatic t_rewind_normal();
    master_reset(1'b0, 1'b1);
    wr(16'h1111); wr(16'h2222); wr(16'h3333);
    settle();
    rd(); rd();
    chk("R8 before rewind", 32'(dout), 32'h2222);
    pulse_rewind();
    chk("R8 dout unchanged at rewind", 32'(dout), 32'h2222);
    settle();
    rd(); chk("R8 word 0 after rewind", 32'(dout), 32'h1111);
    rd(); chk("R8 word 1 after rewind", 32'(dout), 32'h2222);
    rd(); chk("R8 word 2 after rewind", 32'(dout), 32'h3333);
  endtask

  task automatic t_rewind_zero();
    master_reset(1'b0, 1'b0);
    wr(16'h4444); wr(16'h5555); wr(16'h6666);
    settle();
    rd(); rd(); rd();
    settle();
    chk("R9 drained", 32'(empty_n), 0);
    pulse_rewind();
    chk("R9 word 0 on rewind edge", 32'(dout), 32'h4444);
    settle();
    rd(); chk("R9 word 1 next", 32'(dout), 32'h5555);
    rd(); chk("R9 word 2 next", 32'(dout), 32'h6666);
    settle();
    chk("R9 empty after replay", 32'(empty_n), 0);
  endtask

  task automatic t_partial();
    master_reset(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) wr(16'hB000 + 16'(i));
    settle();
    rd();
    chk("R10 pre-reset read", 32'(dout), 32'hB000);
    @(negedge wclk);
    cfg_flag_async = 1'b0; cfg_rt_slow = 1'b1; prst = 1;
    repeat (4) @(negedge rclk);
    prst = 0;
    repeat (2) @(negedge rclk);
    chk("R10 empty_n", 32'(empty_n), 0);
    chk("R10 full_n", 32'(full_n), 1);
    chk("R10 half_n", 32'(half_n), 1);
    chk("R10 almost_empty_n", 32'(almost_empty_n), 0);
    chk("R10 almost_full_n", 32'(almost_full_n), 1);
    chk("R10 dout held", 32'(dout), 32'hB000);
    for (int i = 0; i < 4; i++) wr(16'hC000 + 16'(i));
    chk("R10 async flag mode kept", 32'(almost_empty_n), 1);
    settle();
    rd();
    chk("R10 pointers restarted", 32'(dout), 32'hC000);
    rd();
    pulse_rewind();
    chk("R10 zero-latency rewind kept", 32'(dout), 32'hC000);
  endtask

  initial begin
    repeat (60000) @(posedge wclk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    t_reset();
    t_order_and_empty();
    t_full_half();
    t_sync_flags();
    t_async_flags();
    t_rewind_normal();
    t_rewind_zero();
    t_partial();
    finish_run();
  end
endmodule